// File: doc/BRIEF.md
# LCD Multiplex Row Timing Generator

This block sets the scan timing for a multiplexed LCD driver. A two-bit duty code picks 8, 16, 20 or 24 scanned rows. The block steps a row index through one frame and marks the start of each frame with a one-cycle pulse. It also flips a drive-polarity flag once per frame, so that the panel sees no net DC.

In internal mode, a divider on the reference clock sets the row period so that the frame stays near 75 Hz at every duty. The row rate is therefore 75 Hz times the row count. The frame signal is driven out through the split pin interface (`frame_out` with enable `frame_oe`). In external mode the pin becomes an input. A rising edge on it restarts the scan at row 0, and the internal divider still paces the rows in between. A per-output flag vector marks which driver outputs act as row (common) drivers. In external mode every output is a column driver.

Top module: `lcd_row_timing`

## Requirements
- R1: The duty code `cfg_mux` maps 00 to 8 rows, 01 to 16, 10 to 20 and 11 to 24. The row period is CLK_HZ/(75*rows) clock cycles, with a minimum of one, so a frame lasts about CLK_HZ/75 cycles.
- R2: `row_idx` counts up by one each row period from 0 to rows-1, then returns to 0.
- R3: `frame_start` is high for exactly the one cycle in which row 0 begins after a wrap or a restart. It never rises at any other time, including the first frame after reset.
- R4: `polarity` is 0 after reset and inverts each time `frame_start` is asserted.
- R5: With `cfg_ext_n` = 1 (internal mode), `frame_oe` is 1 from the cycle after the setting, `frame_out` is 1 exactly while `row_idx` is 0, and `frame_in` has no effect on any output.
- R6: With `cfg_ext_n` = 0 (external mode), `frame_oe` is 0. `frame_in` passes through two synchronizer flops. A rising edge restarts the scan: `row_idx` becomes 0, `frame_start` pulses, `polarity` flips and the divider clears. This is visible after the third clock edge that follows the input change. Without edges, rows keep wrapping on the internal period.
- R7: Bit i of `row_role` is 1 when internal mode is selected and i < rows, and 0 otherwise. It takes the configuration one cycle late, so in external mode all bits are 0.
- R8: While `rst` is high, the outputs settle to `row_idx` 0, `frame_start` 0, `polarity` 0, `frame_out` 1, `frame_oe` 0 and `row_role` all zero.
- R9: When `cfg_mux` changes mid-frame, a row index at or above the new rows-1 wraps to 0 on the next row tick. A divider count at or above the new period-1 ticks at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mux | input | 2 | Duty code selecting 8/16/20/24 rows |
| cfg_ext_n | input | 1 | 1 = internal frame timing, 0 = external frame timing |
| frame_in | input | 1 | Frame pin input value (used in external mode) |
| frame_out | output | 1 | Frame pin drive value, high during row 0 |
| frame_oe | output | 1 | Frame pin output enable |
| row_idx | output | 5 | Current row select index |
| frame_start | output | 1 | One-cycle pulse when row 0 begins |
| polarity | output | 1 | AC drive polarity, flips every frame |
| row_role | output | NUM_OUTS | Per-output flag, 1 = row driver |

## Verification
All timing outputs come from registers. A row tick seen during cycle k shows on `row_idx`, `frame_start`, `polarity` and `frame_out` after the edge that closes cycle k. Configuration reaches `frame_oe` and `row_role` one edge after it is applied. An external rising edge needs three edges: two synchronizer stages plus the restart edge. The bench keeps a cycle-level model that follows these rules and advances on the same rising edge as the design. It compares every output at the falling edge, so each result is checked in the cycle it is due. Directed period measurements after reset count the exact cycles between row changes for each duty code.

// File: rtl/lcd_row_pkg.sv
package lcd_row_pkg;
  localparam int ROW_W    = 5;
  localparam int MAX_ROWS = 24;

  typedef enum logic [1:0] {
    DUTY_8  = 2'b00,
    DUTY_16 = 2'b01,
    DUTY_20 = 2'b10,
    DUTY_24 = 2'b11
  } duty_e;

  function automatic logic [ROW_W-1:0] duty_rows(input logic [1:0] code);
    case (duty_e'(code))
      DUTY_8:  duty_rows = ROW_W'(8);
      DUTY_16: duty_rows = ROW_W'(16);
      DUTY_20: duty_rows = ROW_W'(20);
      default: duty_rows = ROW_W'(24);
    endcase
  endfunction

  function automatic int unsigned row_period(input int unsigned clk_hz,
                                             input int unsigned frame_hz,
                                             input int unsigned rows);
    int unsigned q;
    q = clk_hz / (frame_hz * rows);
    row_period = (q == 0) ? 1 : q;
  endfunction
endpackage

// File: rtl/lcd_frame_sync.sv
module lcd_frame_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic rise
);
  logic [2:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 3'b000;
    else     sync_q <= {sync_q[1:0], pin_in};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/lcd_row_divider.sv
module lcd_row_divider
  import lcd_row_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 1_000_000,
  parameter int unsigned FRAME_HZ = 75
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] duty,
  input  logic       restart,
  output logic       tick
);
  localparam int unsigned P8  = row_period(CLK_HZ, FRAME_HZ, 8);
  localparam int unsigned P16 = row_period(CLK_HZ, FRAME_HZ, 16);
  localparam int unsigned P20 = row_period(CLK_HZ, FRAME_HZ, 20);
  localparam int unsigned P24 = row_period(CLK_HZ, FRAME_HZ, 24);
  localparam int CNT_W = $clog2(P8 + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    case (duty_e'(duty))
      DUTY_8:  last_cnt = CNT_W'(P8 - 1);
      DUTY_16: last_cnt = CNT_W'(P16 - 1);
      DUTY_20: last_cnt = CNT_W'(P20 - 1);
      default: last_cnt = CNT_W'(P24 - 1);
    endcase
  end

  assign tick = (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(P8 - 1));
endmodule

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer
  import lcd_row_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] rows,
  input  logic             tick,
  input  logic             restart,
  output logic [ROW_W-1:0] row_idx,
  output logic             frame_start,
  output logic             polarity,
  output logic             frame_out
);
  logic [ROW_W-1:0] row_q, row_nxt;
  logic             wrap;

  assign wrap = restart || (tick && (row_q >= rows - 1'b1));

  always_comb begin
    if (wrap)      row_nxt = '0;
    else if (tick) row_nxt = row_q + 1'b1;
    else           row_nxt = row_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q       <= '0;
      frame_start <= 1'b0;
      polarity    <= 1'b0;
      frame_out   <= 1'b1;
    end else begin
      row_q       <= row_nxt;
      frame_start <= wrap;
      frame_out   <= (row_nxt == '0);
      if (wrap) polarity <= ~polarity;
    end
  end

  assign row_idx = row_q;

  p_start_row0_r3: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (row_idx == '0));

  p_pol_flip_r4: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (polarity != $past(polarity)));

  p_row_step_r2: assert property (@(posedge clk) disable iff (rst)
    (row_idx != $past(row_idx)) |-> ((row_idx == $past(row_idx) + 1'b1) || (row_idx == '0)));

  p_row_max_r2: assert property (@(posedge clk) disable iff (rst)
    row_idx < ROW_W'(MAX_ROWS));
endmodule

// File: rtl/lcd_row_timing.sv
module lcd_row_timing
  import lcd_row_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 1_000_000,
  parameter int unsigned FRAME_HZ = 75,
  parameter int          NUM_OUTS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_mux,
  input  logic                cfg_ext_n,
  input  logic                frame_in,
  output logic                frame_out,
  output logic                frame_oe,
  output logic [ROW_W-1:0]    row_idx,
  output logic                frame_start,
  output logic                polarity,
  output logic [NUM_OUTS-1:0] row_role
);
  logic [ROW_W-1:0] rows;
  logic             ext_rise, restart, tick;

  assign rows    = duty_rows(cfg_mux);
  assign restart = ext_rise && !cfg_ext_n;

  lcd_frame_sync i_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_in (frame_in),
    .rise   (ext_rise)
  );

  lcd_row_divider #(.CLK_HZ(CLK_HZ), .FRAME_HZ(FRAME_HZ)) i_div (
    .clk     (clk),
    .rst     (rst),
    .duty    (cfg_mux),
    .restart (restart),
    .tick    (tick)
  );

  lcd_row_sequencer i_seq (
    .clk         (clk),
    .rst         (rst),
    .rows        (rows),
    .tick        (tick),
    .restart     (restart),
    .row_idx     (row_idx),
    .frame_start (frame_start),
    .polarity    (polarity),
    .frame_out   (frame_out)
  );

  always_ff @(posedge clk) begin
    if (rst) frame_oe <= 1'b0;
    else     frame_oe <= cfg_ext_n;
  end

  for (genvar gi = 0; gi < NUM_OUTS; gi++) begin : g_role
    always_ff @(posedge clk) begin
      if (rst) row_role[gi] <= 1'b0;
      else     row_role[gi] <= cfg_ext_n && (gi < int'(rows));
    end
  end

  p_oe_cfg_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (frame_oe == $past(cfg_ext_n)));

  p_no_rows_ext_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_oe |-> (row_role == '0));

  p_role_count_r7: assert property (@(posedge clk) disable iff (rst)
    frame_oe |-> ($countones(row_role) <= MAX_ROWS));
endmodule

// File: tb/test_lcd_row_timing.sv
module test_lcd_row_timing;
  localparam int unsigned CLK_HZ = 18000;
  localparam int NOUT = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_mux = 2'b00;
  logic cfg_ext_n = 1'b1;
  logic frame_in = 1'b0;
  logic frame_out, frame_oe, frame_start, polarity;
  logic [4:0] row_idx;
  logic [NOUT-1:0] row_role;

  int checks = 0;
  int fails = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_row_timing #(.CLK_HZ(CLK_HZ), .FRAME_HZ(75), .NUM_OUTS(NOUT)) i_lcd_row_timing (
    .clk(clk), .rst(rst), .cfg_mux(cfg_mux), .cfg_ext_n(cfg_ext_n),
    .frame_in(frame_in), .frame_out(frame_out), .frame_oe(frame_oe),
    .row_idx(row_idx), .frame_start(frame_start), .polarity(polarity),
    .row_role(row_role)
  );

  function automatic int rows_of(input logic [1:0] c);
    case (c)
      2'b00: return 8;
      2'b01: return 16;
      2'b10: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int period_of(input int n);
    int q;
    q = int'(CLK_HZ) / (75 * n);
    return (q < 1) ? 1 : q;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bench reference model, built from the requirements
  int m_cnt, m_row;
  bit m_fs, m_pol, m_fo, m_oe;
  logic [NOUT-1:0] m_role;
  bit s1, s2, s3;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_row = 0; m_fs = 0; m_pol = 0; m_fo = 1; m_oe = 0;
      m_role = '0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int n, per;
      bit rise, tck;
      n = rows_of(cfg_mux);
      per = period_of(n);
      rise = s2 && !s3 && !cfg_ext_n;
      tck = (m_cnt >= per - 1);
      s3 = s2; s2 = s1; s1 = frame_in;
      m_oe = cfg_ext_n;
      for (int i = 0; i < NOUT; i++) m_role[i] = cfg_ext_n && (i < n);
      m_fs = 0;
      if (rise) begin
        m_cnt = 0; m_row = 0; m_fs = 1; m_pol = !m_pol;
      end else begin
        m_cnt = tck ? 0 : m_cnt + 1;
        if (tck) begin
          if (m_row >= n - 1) begin
            m_row = 0; m_fs = 1; m_pol = !m_pol;
          end else m_row = m_row + 1;
        end
      end
      m_fo = (m_row == 0);
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check(cfg_ext_n ? "R2/R9" : "R6/R2", int'(row_idx), m_row);
      check(cfg_ext_n ? "R3" : "R6/R3", int'(frame_start), int'(m_fs));
      check(cfg_ext_n ? "R4" : "R6/R4", int'(polarity), int'(m_pol));
      check("R5", int'(frame_out), int'(m_fo));
      check("R5/R6", int'(frame_oe), int'(m_oe));
      check("R7", int'(row_role != m_role), 0);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 row", int'(row_idx), 0);
    check("R8 frame_start", int'(frame_start), 0);
    check("R8 polarity", int'(polarity), 0);
    check("R8 frame_out", int'(frame_out), 1);
    check("R8 frame_oe", int'(frame_oe), 0);
    check("R8 row_role", int'(row_role != '0), 0);
    rst = 1'b0;
  endtask

  // R1: cycles between row 1 and row 2 equal the row period
  task automatic measure_period(input logic [1:0] code);
    int cyc;
    cfg_mux = code; cfg_ext_n = 1'b1; frame_in = 1'b0;
    do_reset();
    while (row_idx != 5'd1) @(negedge clk);
    cyc = 0;
    while (row_idx == 5'd1) begin @(negedge clk); cyc++; end
    check("R1 period", cyc, period_of(rows_of(code)));
    check("R1 next row", int'(row_idx), 2);
  endtask

  task automatic run_phase(input int cycles, input int toggle_odds);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (toggle_odds > 0 && ($urandom % toggle_odds) == 0) frame_in = ~frame_in;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    do_reset();
    for (int k = 0; k < 4; k++) measure_period(2'(k));
    cmp_en = 1'b1;
    do_reset();
    // R5: internal mode with a noisy frame_in that must be ignored
    for (int k = 0; k < 4; k++) begin
      cfg_mux = 2'(k); cfg_ext_n = 1'b1;
      run_phase(500, 7);
    end
    // R6: external mode, directed single edge, then idle wrap
    cfg_ext_n = 1'b0; frame_in = 1'b0; cfg_mux = 2'b01;
    run_phase(100, 0);
    frame_in = 1'b1;
    run_phase(600, 0);
    frame_in = 1'b0;
    // R9 and mixed: random duty / mode changes without reset
    for (int k = 0; k < 14; k++) begin
      cfg_mux = 2'($urandom % 4);
      cfg_ext_n = 1'($urandom % 2);
      run_phase(200 + int'($urandom % 500), 10 + int'($urandom % 60));
    end
    // R9 directed: drop from 24 rows to 8 rows late in a frame
    cfg_ext_n = 1'b1; cfg_mux = 2'b11;
    do_reset();
    while (row_idx != 5'd20) @(negedge clk);
    cfg_mux = 2'b00;
    run_phase(300, 0);
    // R8: reset in the middle of external operation
    cfg_ext_n = 1'b0;
    run_phase(50, 5);
    do_reset();
    run_phase(100, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule